// File: doc/BRIEF.md
# Interrupt Event Filter with Status Merge

This block turns polled snapshots of an I/O expander into a bitmap of pending interrupt events. Each poll delivers two words at the same time under one valid strobe: the interrupt status flags, which mark the lines that latched an interrupt, and the current input levels. The block keeps its own copy of the input levels from the previous accepted poll. Each line has an enable bit and a trigger code, and the block compares the new levels with the stored copy under that code.

Events come from two sources, and they are combined. The change path finds edges by comparing the new levels with the stored copy, so it still catches an edge that arrived after the status word was captured. The status path covers a pulse that went out and came back before the levels were sampled. Such a pulse left a status flag but no visible change. Its direction cannot be known, so the flag is counted as a hit on every edge-type trigger. Level triggers look only at the current level.

Control is a two-state machine. ST_IDLE means no result is pending. The transition "accept" (snap_valid high) moves to ST_REPORT, where `pend_valid` is high for one cycle. The transition "chain" (snap_valid high again while in ST_REPORT) stays in ST_REPORT with the new result. The transition "drain" (snap_valid low while in ST_REPORT) returns to ST_IDLE.

Top module: `irq_event_filter`

## Requirements
- R1: After reset, `pend_valid` is 0, `pend_bits` is 0, and the stored previous level of every line is 0.
- R2: `pend_valid` is 1 in exactly the cycle after each cycle with `snap_valid` high, including back-to-back polls. `pend_bits` is 0 whenever `pend_valid` is 0.
- R3: Trigger code 0 (rising) reports a line whose stored level is 0 and whose new level is 1. A falling change on that line is not reported.
- R4: Trigger code 1 (falling) reports a line whose stored level is 1 and whose new level is 0. A rising change on that line is not reported.
- R5: Trigger code 2 (both edges) reports any line whose new level differs from its stored level.
- R6: Trigger code 3 (high) reports a line whose new level is 1. Trigger code 4 (low) reports a line whose new level is 0. This holds whatever the stored level or the status flag is, and it repeats on every poll.
- R7: On a line with code 0, 1 or 2, a status flag with no level change is reported.
- R8: A qualifying change is reported even when the line's status flag is 0.
- R9: On a line with code 0 or 1, a status flag together with a change in the non-configured direction is not reported.
- R10: A line whose enable bit is 0 never reports an event.
- R11: The stored level of every line, enabled or not, takes the new input word on each poll. When `snap_valid` is low, the inputs have no effect.
- R12: Trigger codes 5, 6 and 7 never report an event.
- R13: Lines are evaluated independently. A mix of codes across the lines in one poll gives each line its own result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_en | input | N_LINES | Per-line interrupt enable |
| cfg_mode | input | 3*N_LINES | Per-line trigger code; line i uses bits [3i+2:3i] |
| snap_valid | input | 1 | Qualifies the two snapshot words |
| snap_status | input | N_LINES | Status flag snapshot |
| snap_input | input | N_LINES | Input level snapshot |
| pend_valid | output | 1 | One-cycle strobe for a new result |
| pend_bits | output | N_LINES | Pending event bitmap |

## Verification
The polls are chosen so that each tells two explanations apart. A change with a zero status word shows that the change path works on its own. A status word with unchanged levels shows that the status path works on its own. A status flag paired with an opposite-direction edge shows that a flag alone is not counted as an event when the direction is known. Repeated identical polls on level lines show that level triggers do not depend on the stored state. A poll made while lines are disabled, followed by re-enabling them with no change in level, shows whether disabled lines kept their stored level up to date. A mixed-code poll and a pair of back-to-back polls check that lines and cycles stay independent.

// File: rtl/irq_filt_pkg.sv
package irq_filt_pkg;

    localparam int unsigned MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        TRIG_RISE = 3'd0,
        TRIG_FALL = 3'd1,
        TRIG_BOTH = 3'd2,
        TRIG_HIGH = 3'd3,
        TRIG_LOW  = 3'd4
    } trig_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } rep_state_e;

endpackage

// File: rtl/irq_line_eval.sv
module irq_line_eval
    import irq_filt_pkg::*;
(
    input  logic              en,
    input  logic [MODE_W-1:0] mode,
    input  logic              prev_lvl,
    input  logic              new_lvl,
    input  logic              flag,
    output logic              hit
);
    logic moved;
    logic went_up;
    logic went_down;
    logic hidden_pulse;
    logic raw;

    always_comb begin
        moved        = prev_lvl ^ new_lvl;
        went_up      = moved & new_lvl;
        went_down    = moved & ~new_lvl;
        hidden_pulse = flag & ~moved;
        unique case (mode)
            TRIG_RISE: raw = went_up   | hidden_pulse;
            TRIG_FALL: raw = went_down | hidden_pulse;
            TRIG_BOTH: raw = moved     | hidden_pulse;
            TRIG_HIGH: raw = new_lvl;
            TRIG_LOW:  raw = ~new_lvl;
            default:   raw = 1'b0;
        endcase
        hit = en & raw;
    end
endmodule

// File: rtl/irq_prev_store.sv
module irq_prev_store #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] next_lvl,
    output logic [WIDTH-1:0] lvl_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= '0;
        end else if (load) begin
            lvl_q <= next_lvl;
        end
    end
endmodule

// File: rtl/irq_event_filter.sv
module irq_event_filter
    import irq_filt_pkg::*;
#(
    parameter int unsigned N_LINES = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_LINES-1:0]        cfg_en,
    input  logic [MODE_W*N_LINES-1:0] cfg_mode,
    input  logic                      snap_valid,
    input  logic [N_LINES-1:0]        snap_status,
    input  logic [N_LINES-1:0]        snap_input,
    output logic                      pend_valid,
    output logic [N_LINES-1:0]        pend_bits
);
    localparam int unsigned MODE_BITS = MODE_W * N_LINES;

    rep_state_e           state_q;
    rep_state_e           state_d;
    logic [N_LINES-1:0]   prev_lvl;
    logic [N_LINES-1:0]   hits;
    logic [N_LINES-1:0]   bits_q;

    irq_prev_store #(.WIDTH(N_LINES)) u_prev (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (snap_valid),
        .next_lvl (snap_input),
        .lvl_q    (prev_lvl)
    );

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        irq_line_eval u_eval (
            .en       (cfg_en[i]),
            .mode     (cfg_mode[MODE_W*i +: MODE_W]),
            .prev_lvl (prev_lvl[i]),
            .new_lvl  (snap_input[i]),
            .flag     (snap_status[i]),
            .hit      (hits[i])
        );
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (snap_valid)  state_d = ST_REPORT;
            ST_REPORT: if (!snap_valid) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else if (snap_valid) begin
            bits_q <= hits;
        end else begin
            bits_q <= '0;
        end
    end

    assign pend_valid = (state_q == ST_REPORT);
    assign pend_bits  = bits_q;

    logic unused_width;
    assign unused_width = (MODE_BITS == 0);
endmodule

// File: rtl/irq_event_filter_chk.sv
module irq_event_filter_chk
    import irq_filt_pkg::*;
#(
    parameter int unsigned N_LINES = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [N_LINES-1:0]        cfg_en,
    input logic [MODE_W*N_LINES-1:0] cfg_mode,
    input logic                      snap_valid,
    input logic [N_LINES-1:0]        snap_status,
    input logic [N_LINES-1:0]        snap_input,
    input logic                      pend_valid,
    input logic [N_LINES-1:0]        pend_bits
);
    logic [N_LINES-1:0] seen_lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_lvl <= '0;
        end else if (snap_valid) begin
            seen_lvl <= snap_input;
        end
    end

    AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        snap_valid |=> pend_valid); // R2
    AST_STROBE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_valid |=> !pend_valid); // R2
    AST_BITS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_valid |-> (pend_bits == '0)); // R2
    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        snap_valid |=> ((pend_bits & ~$past(cfg_en)) == '0)); // R10

    for (genvar i = 0; i < N_LINES; i++) begin : g_chk
        logic [MODE_W-1:0] m;
        assign m = cfg_mode[MODE_W*i +: MODE_W];

        AST_LEVEL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
            (snap_valid && cfg_en[i] && m == TRIG_HIGH && snap_input[i]) |=> pend_bits[i]); // R6
        AST_LEVEL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            (snap_valid && cfg_en[i] && m == TRIG_LOW && !snap_input[i]) |=> pend_bits[i]); // R6
        AST_HIDDEN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
            (snap_valid && cfg_en[i] && m <= TRIG_BOTH && snap_status[i]
             && snap_input[i] == seen_lvl[i]) |=> pend_bits[i]); // R7
        AST_RESERVED_CODE: assert property (@(posedge clk) disable iff (!rst_n)
            (snap_valid && m > TRIG_LOW) |=> !pend_bits[i]); // R12
    end
endmodule

bind irq_event_filter irq_event_filter_chk #(.N_LINES(N_LINES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_en      (cfg_en),
    .cfg_mode    (cfg_mode),
    .snap_valid  (snap_valid),
    .snap_status (snap_status),
    .snap_input  (snap_input),
    .pend_valid  (pend_valid),
    .pend_bits   (pend_bits)
);

// File: tb/tb_irq_event_filter.sv
module tb_irq_event_filter;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] cfg_en = '0;
    logic [3*N-1:0] cfg_mode = '0;
    logic         snap_valid = 1'b0;
    logic [N-1:0] snap_status = '0;
    logic [N-1:0] snap_input = '0;
    logic         pend_valid;
    logic [N-1:0] pend_bits;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    irq_event_filter #(.N_LINES(N)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_mode(cfg_mode),
        .snap_valid(snap_valid), .snap_status(snap_status), .snap_input(snap_input),
        .pend_valid(pend_valid), .pend_bits(pend_bits)
    );

    task automatic check(input string req, input logic v_exp, input logic [N-1:0] b_exp);
        total++;
        if (pend_valid !== v_exp || pend_bits !== b_exp) begin
            bad++;
            $display("FAIL %s: valid=%0b bits=%02h expected valid=%0b bits=%02h",
                     req, pend_valid, pend_bits, v_exp, b_exp);
        end
    endtask

    task automatic all_mode(input logic [2:0] m);
        for (int i = 0; i < N; i++) cfg_mode[3*i +: 3] = m;
    endtask

    task automatic poll(input logic [N-1:0] st, input logic [N-1:0] lv,
                        input logic [N-1:0] exp, input string req);
        @(negedge clk);
        snap_valid = 1'b1; snap_status = st; snap_input = lv;
        @(negedge clk);
        snap_valid = 1'b0;
        check(req, 1'b1, exp);
    endtask

    task automatic t_reset();
        check("R1", 1'b0, '0);
    endtask

    task automatic t_rise();
        cfg_en = '1; all_mode(3'd0);
        poll(8'h00, 8'h0F, 8'h0F, "R3/R8");
        @(negedge clk);
        check("R2", 1'b0, '0);
        poll(8'h00, 8'h03, 8'h00, "R3");
    endtask

    task automatic t_fall();
        all_mode(3'd1);
        poll(8'h00, 8'h01, 8'h02, "R4/R8");
        poll(8'h00, 8'h81, 8'h00, "R4");
    endtask

    task automatic t_both();
        all_mode(3'd2);
        poll(8'h00, 8'h18, 8'h99, "R5");
    endtask

    task automatic t_status_only();
        all_mode(3'd0); poll(8'h24, 8'h18, 8'h24, "R7 rise");
        all_mode(3'd1); poll(8'h42, 8'h18, 8'h42, "R7 fall");
        all_mode(3'd2); poll(8'h81, 8'h18, 8'h81, "R7 both");
        all_mode(3'd0); poll(8'h10, 8'h08, 8'h00, "R9");
    endtask

    task automatic t_level();
        for (int i = 0; i < N; i++) cfg_mode[3*i +: 3] = (i < 4) ? 3'd3 : 3'd4;
        poll(8'hFF, 8'h35, 8'hC5, "R6");
        poll(8'h00, 8'h35, 8'hC5, "R6 repeat");
    endtask

    task automatic t_disabled();
        all_mode(3'd2); cfg_en = 8'h0F;
        poll(8'hF0, 8'hCA, 8'h0F, "R10");
        cfg_en = '1; all_mode(3'd0);
        poll(8'h00, 8'hCA, 8'h00, "R11 tracked");
    endtask

    task automatic t_ignored();
        all_mode(3'd2);
        @(negedge clk);
        snap_input = 8'h00; snap_status = 8'hFF;
        repeat (3) @(negedge clk);
        check("R11 idle", 1'b0, '0);
        poll(8'h00, 8'hCA, 8'h00, "R11 unchanged");
    endtask

    task automatic t_reserved();
        all_mode(3'd7); poll(8'hFF, 8'h35, 8'h00, "R12 code7");
        all_mode(3'd6); poll(8'hFF, 8'hCA, 8'h00, "R12 code6");
        all_mode(3'd5); poll(8'hFF, 8'h35, 8'h00, "R12 code5");
    endtask

    task automatic t_mixed();
        cfg_mode = {3'd5, 3'd1, 3'd0, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0};
        poll(8'hA0, 8'hFB, 8'h2C, "R13");
    endtask

    task automatic t_back_to_back();
        all_mode(3'd2);
        @(negedge clk);
        snap_valid = 1'b1; snap_status = '0; snap_input = 8'h00;
        @(negedge clk);
        snap_input = 8'h01;
        check("R2 first", 1'b1, 8'hFB);
        @(negedge clk);
        snap_valid = 1'b0;
        check("R2 second", 1'b1, 8'h01);
        @(negedge clk);
        check("R2 drain", 1'b0, '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rise();
        t_fall();
        t_both();
        t_status_only();
        t_level();
        t_disabled();
        t_ignored();
        t_reserved();
        t_mixed();
        t_back_to_back();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule